// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block converts the addressing fields of an interrupt message into a set of target agents. The fields are a destination byte, a physical/logical mode bit, a two-bit shorthand and a three-bit delivery mode. The result is a bitmask with one bit per receiving agent. Each of the N agents presents three fields to the resolver:

- its physical ID
- an 8-bit logical address
- a 4-bit addressing model, either flat or cluster

The resolver decodes the message against all agents in parallel. It applies the shorthand override, and for lowest-priority delivery it narrows the set to a single agent.

A one-cycle request strobe samples all inputs. The resulting mask is registered and appears on the next clock edge, together with a one-cycle valid pulse. The mask then holds until the next request or a reset.

The interface has no back-pressure. A request is accepted on every cycle its strobe is high, and the consumer must take the result in the cycle its valid is high.

Top module: `irq_dest_resolver`

## Requirements
- R1: A synchronous active-high reset clears the mask output to zero and holds the valid output low.
- R2: The valid output is high in exactly the cycle after each cycle in which the request strobe was high. Otherwise it is low. Between results the mask output keeps its last value.
- R3: With the mode bit at 0 (physical) and shorthand 0, a destination of 0xFF selects all N agents.
- R4: With the mode bit at 0 (physical) and shorthand 0, any other destination selects every agent whose physical ID equals it. If no agent has that ID, the mask is zero.
- R5: With the mode bit at 1 (logical), an agent with model 0xF (flat) is selected when the bitwise AND of the destination and its logical address is nonzero.
- R6: With the mode bit at 1, an agent with model 0x0 (cluster) is selected only when two conditions hold. Destination bits [7:4] must equal its logical address bits [7:4]. The AND of the two bits [3:0] fields must also be nonzero.
- R7: With the mode bit at 1, an agent whose model is neither 0xF nor 0x0 is never selected.
- R8: Shorthand 1 selects only the agent or agents whose physical ID equals the sender ID, ignoring destination and mode.
- R9: Shorthand 2 selects all N agents.
- R10: Shorthand 3 selects all agents except those whose physical ID equals the sender ID.
- R11: With delivery mode 1 (lowest priority), only the lowest-numbered set bit of the mask from R3 to R10 is kept, and a zero mask stays zero. Every other delivery mode passes the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; samples all request and agent inputs |
| dest | input | 8 | Destination byte of the message |
| dest_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| shorthand | input | 2 | 0 = decode destination, 1 = sender only, 2 = all, 3 = all but sender |
| dlv_mode | input | 3 | Delivery mode; 1 = lowest priority |
| sender_id | input | 8 | Physical ID of the sending agent |
| agent_phys_id | input | N*8 | Physical ID of agent i in bits [8i+7:8i] |
| agent_log_dest | input | N*8 | Logical address of agent i in bits [8i+7:8i] |
| agent_model | input | N*4 | Addressing model of agent i in bits [4i+3:4i]; 0xF flat, 0x0 cluster |
| mask_out | output | N | Registered target mask; bit i is agent i |
| mask_valid | output | 1 | One-cycle pulse marking a new mask |

## Verification
Every result is due exactly one clock edge after the edge that sees the request strobe high, because there is one register between the inputs and the outputs.

The driver raises the strobe at a falling edge and pushes the mask it computes from the requirements into a queue. The monitor samples at the next falling edge, when the valid pulse and the mask are both settled, and compares them with the front of the queue. A valid pulse with an empty queue is flagged. During idle stretches the bench confirms that valid stays low and that the mask is held.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  typedef enum logic [1:0] {
    SH_DECODE = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [2:0] DLV_LOWEST    = 3'd1;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;
endpackage

// File: rtl/dmr_agent_match.sv
module dmr_agent_match
  import dmr_pkg::*;
(
  input  logic [7:0] dest,
  input  logic       logical,
  input  logic [7:0] phys_id,
  input  logic [7:0] log_dest,
  input  logic [3:0] model,
  output logic       hit
);
  logic [7:0] overlap;
  logic       group_eq;

  assign overlap  = dest & log_dest;
  assign group_eq = (dest[7:4] == log_dest[7:4]);

  always_comb begin
    hit = 1'b0;
    if (!logical) begin
      hit = (dest == DEST_BCAST) || (dest == phys_id);
    end else begin
      unique case (model)
        MODEL_FLAT:    hit = |overlap;
        MODEL_CLUSTER: hit = group_eq && (|overlap[3:0]);
        default:       hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dmr_shorthand_sel.sv
module dmr_shorthand_sel
  import dmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] decode_mask,
  input  logic [W-1:0] self_mask,
  input  logic [1:0]   shorthand,
  output logic [W-1:0] sel_mask
);
  shorthand_e sh;
  assign sh = shorthand_e'(shorthand);

  always_comb begin
    unique case (sh)
      SH_DECODE: sel_mask = decode_mask;
      SH_SELF:   sel_mask = self_mask;
      SH_ALL:    sel_mask = '1;
      SH_OTHERS: sel_mask = ~self_mask;
      default:   sel_mask = '0;
    endcase
  end
endmodule

// File: rtl/dmr_lowest_pick.sv
module dmr_lowest_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_mask,
  input  logic         enable,
  output logic [W-1:0] out_mask
);
  logic [W-1:0] lowest;
  assign lowest   = in_mask & (~in_mask + {{(W-1){1'b0}}, 1'b1});
  assign out_mask = enable ? lowest : in_mask;
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import dmr_pkg::*;
#(
  parameter int N     = 16,
  parameter int ID_W  = 8,
  parameter int MDL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        dest,
  input  logic              dest_logical,
  input  logic [1:0]        shorthand,
  input  logic [2:0]        dlv_mode,
  input  logic [ID_W-1:0]   sender_id,
  input  logic [N*ID_W-1:0] agent_phys_id,
  input  logic [N*ID_W-1:0] agent_log_dest,
  input  logic [N*MDL_W-1:0] agent_model,
  output logic [N-1:0]      mask_out,
  output logic              mask_valid
);
  logic [N-1:0] decode_mask;
  logic [N-1:0] self_mask;
  logic [N-1:0] sel_mask;
  logic [N-1:0] final_mask;

  for (genvar i = 0; i < N; i++) begin : g_agent
    dmr_agent_match u_match (
      .dest     (dest),
      .logical  (dest_logical),
      .phys_id  (agent_phys_id[i*ID_W +: ID_W]),
      .log_dest (agent_log_dest[i*ID_W +: ID_W]),
      .model    (agent_model[i*MDL_W +: MDL_W]),
      .hit      (decode_mask[i])
    );
    assign self_mask[i] = (agent_phys_id[i*ID_W +: ID_W] == sender_id);
  end

  dmr_shorthand_sel #(.W(N)) u_sel (
    .decode_mask (decode_mask),
    .self_mask   (self_mask),
    .shorthand   (shorthand),
    .sel_mask    (sel_mask)
  );

  dmr_lowest_pick #(.W(N)) u_pick (
    .in_mask  (sel_mask),
    .enable   (dlv_mode == DLV_LOWEST),
    .out_mask (final_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_out   <= '0;
      mask_valid <= 1'b0;
    end else begin
      mask_valid <= req_valid;
      if (req_valid) mask_out <= final_mask;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (mask_out == '0 && !mask_valid));

  // R2
  pulse_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> mask_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!mask_valid && $stable(mask_out)));

  // R11
  lowest_single_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dlv_mode == DLV_LOWEST) |=> $onehot0(mask_out));

  // R9
  all_full_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && shorthand == 2'd2 && dlv_mode != DLV_LOWEST) |=> (&mask_out));
endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;
  localparam int N = 16;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           rst;
  logic           req_valid;
  logic [7:0]     dest;
  logic           dest_logical;
  logic [1:0]     shorthand;
  logic [2:0]     dlv_mode;
  logic [7:0]     sender_id;
  logic [N*8-1:0] agent_phys_id;
  logic [N*8-1:0] agent_log_dest;
  logic [N*4-1:0] agent_model;
  logic [N-1:0]   mask_out;
  logic           mask_valid;

  logic [7:0] pid [N];
  logic [7:0] ldst[N];
  logic [3:0] mdl [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      agent_phys_id[i*8 +: 8]  = pid[i];
      agent_log_dest[i*8 +: 8] = ldst[i];
      agent_model[i*4 +: 4]    = mdl[i];
    end
  end

  irq_dest_resolver u_irq_dest_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .dest(dest),
    .dest_logical(dest_logical), .shorthand(shorthand), .dlv_mode(dlv_mode),
    .sender_id(sender_id), .agent_phys_id(agent_phys_id),
    .agent_log_dest(agent_log_dest), .agent_model(agent_model),
    .mask_out(mask_out), .mask_valid(mask_valid)
  );

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic [N-1:0] last_exp = '0;

  function automatic logic [N-1:0] model_mask(input logic [7:0] d, input logic lg,
      input logic [1:0] sh, input logic [2:0] dm, input logic [7:0] snd);
    logic [N-1:0] dec, slf, m, r;
    logic found;
    for (int i = 0; i < N; i++) begin
      if (!lg) dec[i] = (d == 8'hFF) || (pid[i] == d);
      else if (mdl[i] == 4'hF) dec[i] = ((d & ldst[i]) != 8'h00);
      else if (mdl[i] == 4'h0) dec[i] = (d[7:4] == ldst[i][7:4]) && ((d[3:0] & ldst[i][3:0]) != 4'h0);
      else dec[i] = 1'b0;
      slf[i] = (pid[i] == snd);
    end
    case (sh)
      2'd0: m = dec;
      2'd1: m = slf;
      2'd2: m = '1;
      default: m = ~slf;
    endcase
    if (dm == 3'd1) begin
      r = '0; found = 1'b0;
      for (int i = 0; i < N; i++)
        if (m[i] && !found) begin r[i] = 1'b1; found = 1'b1; end
      m = r;
    end
    return m;
  endfunction

  task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
      input logic [2:0] dm, input logic [7:0] snd, input string tag);
    @(negedge clk);
    dest = d; dest_logical = lg; shorthand = sh; dlv_mode = dm; sender_id = snd;
    req_valid = 1'b1;
    last_exp = model_mask(d, lg, sh, dm, snd);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(input logic cond, input string tag, input logic [N-1:0] act,
      input logic [N-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    if (!rst && mask_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", mask_out, '0);
      end else begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mask_out == e, t, mask_out, e);
      end
    end
  end

  task automatic set_ids_identity();
    for (int i = 0; i < N; i++) begin
      pid[i] = 8'(i); ldst[i] = 8'h00; mdl[i] = 4'hF;
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; dest = '0; dest_logical = 1'b0;
    shorthand = '0; dlv_mode = '0; sender_id = '0;
    set_ids_identity();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mask_out == '0 && !mask_valid, "R1 reset state", mask_out, '0);

    // physical
    send(8'hFF, 1'b0, 2'd0, 3'd0, 8'd0, "R3 broadcast");
    send(8'd5,  1'b0, 2'd0, 3'd0, 8'd0, "R4 unicast 5");
    send(8'h40, 1'b0, 2'd0, 3'd0, 8'd0, "R4 no agent");
    for (int i = 0; i < N; i++) pid[i] = 8'(N - 1 - i);
    send(8'd5,  1'b0, 2'd0, 3'd0, 8'd0, "R4 permuted ids");
    set_ids_identity();

    // flat logical
    for (int i = 0; i < N; i++) begin ldst[i] = 8'(1 << (i % 8)); mdl[i] = 4'hF; end
    send(8'h05, 1'b1, 2'd0, 3'd0, 8'd0, "R5 flat match");
    send(8'h05, 1'b1, 2'd0, 3'd1, 8'd0, "R11 lowest of flat");

    // cluster logical
    for (int i = 0; i < N; i++) begin
      ldst[i] = {4'(i / 4), 4'(1 << (i % 4))}; mdl[i] = 4'h0;
    end
    send(8'h23, 1'b1, 2'd0, 3'd0, 8'd0, "R6 cluster 2 members 0,1");
    send(8'h13, 1'b1, 2'd0, 3'd0, 8'd0, "R6 cluster 1");
    send(8'h20, 1'b1, 2'd0, 3'd0, 8'd0, "R6 empty member field");

    // mixed and invalid models
    for (int i = 0; i < N; i++) begin
      ldst[i] = 8'hFF;
      mdl[i] = (i % 4 == 0) ? 4'hF : (i % 4 == 1) ? 4'h0 : (i % 4 == 2) ? 4'h5 : 4'h3;
    end
    send(8'hFF, 1'b1, 2'd0, 3'd0, 8'd0, "R7 other models ignored");
    set_ids_identity();

    // shorthands
    send(8'h00, 1'b0, 2'd1, 3'd0, 8'd7, "R8 self");
    send(8'h00, 1'b1, 2'd2, 3'd0, 8'd7, "R9 all");
    send(8'h00, 1'b0, 2'd3, 3'd0, 8'd0, "R10 all but self");
    send(8'h00, 1'b0, 2'd3, 3'd1, 8'd0, "R11 lowest of others");
    send(8'hFF, 1'b0, 2'd0, 3'd1, 8'd0, "R11 lowest of broadcast");
    send(8'h00, 1'b0, 2'd3, 3'd2, 8'd9, "R11 non-lowest unchanged");
    send(8'h80, 1'b0, 2'd0, 3'd1, 8'd0, "R11 empty stays empty");

    // hold and idle
    send(8'd3, 1'b0, 2'd0, 3'd0, 8'd0, "R4 unicast 3");
    repeat (3) @(negedge clk);
    check(!mask_valid && mask_out == last_exp, "R2 hold while idle", mask_out, last_exp);
    check(exp_q.size() == 0, "R2 all results seen", N'(exp_q.size()), '0);

    // mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mask_out == '0 && !mask_valid, "R1 reset after use", mask_out, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule